// File: doc/BRIEF.md
# Pseudo-Two-Port Bank Router

This block sits between two independent command ports and a memory built from several single-port banks. Each port issues its own bank address, row, column and a command code (idle, activate, precharge, read or write) every cycle. The router keeps track of which banks have an open row. It decides which commands may execute and steers a dedicated global write bus and a dedicated global read bus onto the local data lines of the banks it selects. A read on one port and a write on the other can therefore complete in the same cycle when they touch different banks.

Each bank's bidirectional local lines are modelled as a direction strobe (`bank_we`), an outgoing write-data slice and an incoming read-data slice. The crosspoint drives a bank's write slice only while that bank is selected for a write. The read bus takes data only from the bank selected for a read. Combinations of commands that cannot be served raise one-cycle error pulses and are partly or fully dropped.

Top module: `p2p_bank_router`

## Requirements
- R1: After reset, and after any later reset, every bank is closed and all bank strobes, `gr_valid` and all error flags are 0.
- R2: Command codes per port are 0 idle, 1 activate, 2 precharge, 3 read, 4 write. Activate opens the addressed bank with the given row, and precharge closes it. When both ports activate or precharge the same bank in one cycle, port A's command takes effect.
- R3: A read on both ports in one cycle pulses `err_dual_rd`, and a write on both ports pulses `err_dual_wr`, one cycle later. Port A's command executes and port B's is dropped.
- R4: A read on one port and a write on the other to two different open banks both execute. One cycle after the command, the write bank has `bank_en` and `bank_we` high, its address slice is {open row, column} and its write slice carries the `gw_data` value from the command cycle.
- R5: A bank's write-data slice is zero unless that bank is write-selected, and no bank is read-selected and write-selected in the same cycle.
- R6: Reads may be issued every cycle to one bank while writes are issued every cycle to another bank, with no lost command.
- R7: A same-cycle read and write to the same bank pulse `err_clash` one cycle later. The write is dropped and the read proceeds.
- R8: A read or write to a bank that is closed at the start of the cycle pulses `err_closed` one cycle later and is not executed. A same-cycle activate from the other port does not make it legal.
- R9: The data of an executed read appears on `gr_data` with `gr_valid` high two cycles after the command. `gr_port` is 0 for port A and 1 for port B.
- R10: A read or write uses the row that was open in its bank when the command was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_cmd | input | 3 | Port A command code |
| a_bank | input | BANK_W | Port A bank address |
| a_row | input | ROW_W | Port A row (used by activate) |
| a_col | input | COL_W | Port A column (used by read and write) |
| b_cmd | input | 3 | Port B command code |
| b_bank | input | BANK_W | Port B bank address |
| b_row | input | ROW_W | Port B row (used by activate) |
| b_col | input | COL_W | Port B column (used by read and write) |
| gw_data | input | DATA_W | Global write bus, valid with the write command |
| gr_data | output | DATA_W | Global read bus |
| gr_valid | output | 1 | Read bus strobe |
| gr_port | output | 1 | Port that issued the read on the bus |
| bank_en | output | NUM_BANKS | Per-bank access strobe |
| bank_we | output | NUM_BANKS | Per-bank direction: 1 write, 0 read |
| bank_addr | output | NUM_BANKS*(ROW_W+COL_W) | Per-bank {row, column} |
| bank_wdata | output | NUM_BANKS*DATA_W | Per-bank local write data |
| bank_rdata | input | NUM_BANKS*DATA_W | Per-bank local read data |
| err_dual_rd | output | 1 | Both ports read in one cycle |
| err_dual_wr | output | 1 | Both ports wrote in one cycle |
| err_clash | output | 1 | Read and write to one bank in one cycle |
| err_closed | output | 1 | Access to a closed bank |

## Verification
A read from one port and a write from the other can fall in the same cycle. This is the case the crosspoint exists for. The stimulus table pairs them on two different banks in both port orders, on the same bank, and in a back-to-back stream where a read and a write arrive every cycle. Each case is judged at two points: the bank strobes, address and write data one cycle later, and the read bus two cycles later. The bank model returns a known filler word for any bank not being read, so a wrong read mux shows up as wrong data.

// File: rtl/p2p_router_pkg.sv
package p2p_router_pkg;
  localparam int CMD_W = 3;
  typedef enum logic [CMD_W-1:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_PRE  = 3'd2,
    CMD_RD   = 3'd3,
    CMD_WR   = 3'd4
  } cmd_e;
endpackage

// File: rtl/p2p_port_decode.sv
module p2p_port_decode
  import p2p_router_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output logic             is_act,
  output logic             is_pre,
  output logic             is_rd,
  output logic             is_wr
);
  assign is_act = (cmd == CMD_ACT);
  assign is_pre = (cmd == CMD_PRE);
  assign is_rd  = (cmd == CMD_RD);
  assign is_wr  = (cmd == CMD_WR);
endmodule

// File: rtl/p2p_bank_state.sv
module p2p_bank_state #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       a_act,
  input  logic                       a_pre,
  input  logic [BANK_W-1:0]          a_bank,
  input  logic [ROW_W-1:0]           a_row,
  input  logic                       b_act,
  input  logic                       b_pre,
  input  logic [BANK_W-1:0]          b_bank,
  input  logic [ROW_W-1:0]           b_row,
  output logic [NUM_BANKS-1:0]       open_vec,
  output logic [NUM_BANKS*ROW_W-1:0] row_flat
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             open_r;
    logic [ROW_W-1:0] row_r;
    logic             hit_a, hit_b;
    assign hit_a = (a_bank == BANK_W'(g)) && (a_act || a_pre);
    assign hit_b = (b_bank == BANK_W'(g)) && (b_act || b_pre);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_r <= 1'b0;
        row_r  <= '0;
      end else if (hit_a) begin
        open_r <= a_act;
        if (a_act) row_r <= a_row;
      end else if (hit_b) begin
        open_r <= b_act;
        if (b_act) row_r <= b_row;
      end
    end

    assign open_vec[g]                 = open_r;
    assign row_flat[g*ROW_W +: ROW_W]  = row_r;
  end
endmodule

// File: rtl/p2p_crosspoint.sv
module p2p_crosspoint #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_go,
  input  logic [BANK_W-1:0]           rd_bank,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic                        rd_port,
  input  logic                        wr_go,
  input  logic [BANK_W-1:0]           wr_bank,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [NUM_BANKS-1:0]        rd_sel,
  output logic [NUM_BANKS-1:0]        wr_sel,
  output logic [NUM_BANKS-1:0]        bank_en,
  output logic [NUM_BANKS-1:0]        bank_we,
  output logic [NUM_BANKS*ADDR_W-1:0] bank_addr,
  output logic [NUM_BANKS*DATA_W-1:0] bank_wdata,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic [DATA_W-1:0]           gr_data,
  output logic                        gr_valid,
  output logic                        gr_port
);
  function automatic logic [NUM_BANKS-1:0] bank_mask(input logic go, input logic [BANK_W-1:0] bk);
    return go ? (NUM_BANKS'(1) << bk) : '0;
  endfunction

  logic [ADDR_W-1:0] rd_addr_q, wr_addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_port_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_sel    <= '0;
      wr_sel    <= '0;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      wdata_q   <= '0;
      rd_port_q <= 1'b0;
    end else begin
      rd_sel    <= bank_mask(rd_go, rd_bank);
      wr_sel    <= bank_mask(wr_go, wr_bank);
      rd_addr_q <= rd_addr;
      wr_addr_q <= wr_addr;
      wdata_q   <= wr_go ? wdata : '0;
      rd_port_q <= rd_port;
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_lane
    assign bank_en[g] = rd_sel[g] | wr_sel[g];
    assign bank_we[g] = wr_sel[g];
    assign bank_addr[g*ADDR_W +: ADDR_W] =
      wr_sel[g] ? wr_addr_q : (rd_sel[g] ? rd_addr_q : '0);
    assign bank_wdata[g*DATA_W +: DATA_W] = wr_sel[g] ? wdata_q : '0;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (rd_sel[i]) rd_mux = rd_mux | bank_rdata[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gr_data  <= '0;
      gr_valid <= 1'b0;
      gr_port  <= 1'b0;
    end else begin
      gr_data  <= rd_mux;
      gr_valid <= |rd_sel;
      gr_port  <= (|rd_sel) & rd_port_q;
    end
  end
endmodule

// File: rtl/p2p_bank_router.sv
module p2p_bank_router
  import p2p_router_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ADDR_W   = ROW_W + COL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CMD_W-1:0]            a_cmd,
  input  logic [BANK_W-1:0]           a_bank,
  input  logic [ROW_W-1:0]            a_row,
  input  logic [COL_W-1:0]            a_col,
  input  logic [CMD_W-1:0]            b_cmd,
  input  logic [BANK_W-1:0]           b_bank,
  input  logic [ROW_W-1:0]            b_row,
  input  logic [COL_W-1:0]            b_col,
  input  logic [DATA_W-1:0]           gw_data,
  output logic [DATA_W-1:0]           gr_data,
  output logic                        gr_valid,
  output logic                        gr_port,
  output logic [NUM_BANKS-1:0]        bank_en,
  output logic [NUM_BANKS-1:0]        bank_we,
  output logic [NUM_BANKS*ADDR_W-1:0] bank_addr,
  output logic [NUM_BANKS*DATA_W-1:0] bank_wdata,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic                        err_dual_rd,
  output logic                        err_dual_wr,
  output logic                        err_clash,
  output logic                        err_closed
);
  logic a_act, a_pre, a_rd, a_wr;
  logic b_act, b_pre, b_rd, b_wr;

  p2p_port_decode i_dec_a (.cmd(a_cmd), .is_act(a_act), .is_pre(a_pre), .is_rd(a_rd), .is_wr(a_wr));
  p2p_port_decode i_dec_b (.cmd(b_cmd), .is_act(b_act), .is_pre(b_pre), .is_rd(b_rd), .is_wr(b_wr));

  logic [NUM_BANKS-1:0]       open_vec;
  logic [NUM_BANKS*ROW_W-1:0] row_flat;

  p2p_bank_state #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) i_state (
    .clk(clk), .rst_n(rst_n),
    .a_act(a_act), .a_pre(a_pre), .a_bank(a_bank), .a_row(a_row),
    .b_act(b_act), .b_pre(b_pre), .b_bank(b_bank), .b_row(b_row),
    .open_vec(open_vec), .row_flat(row_flat)
  );

  function automatic logic [ROW_W-1:0] row_of(input logic [BANK_W-1:0] bk,
                                              input logic [NUM_BANKS*ROW_W-1:0] rows);
    return rows[bk*ROW_W +: ROW_W];
  endfunction

  // Arbitration: port A wins a same-kind pair
  logic              rd_any, wr_any, rd_is_b, wr_is_b;
  logic [BANK_W-1:0] rd_bank, wr_bank;
  logic [COL_W-1:0]  rd_col, wr_col;
  logic              ev_dual_rd, ev_dual_wr, ev_clash, ev_rd_closed, ev_wr_closed;
  logic              rd_go, wr_go;
  logic [ADDR_W-1:0] rd_addr, wr_addr;

  assign rd_any  = a_rd | b_rd;
  assign wr_any  = a_wr | b_wr;
  assign rd_is_b = ~a_rd;
  assign wr_is_b = ~a_wr;
  assign rd_bank = rd_is_b ? b_bank : a_bank;
  assign wr_bank = wr_is_b ? b_bank : a_bank;
  assign rd_col  = rd_is_b ? b_col : a_col;
  assign wr_col  = wr_is_b ? b_col : a_col;

  assign ev_dual_rd   = a_rd & b_rd;
  assign ev_dual_wr   = a_wr & b_wr;
  assign ev_clash     = rd_any & wr_any & (rd_bank == wr_bank);
  assign ev_rd_closed = rd_any & ~open_vec[rd_bank];
  assign ev_wr_closed = wr_any & ~open_vec[wr_bank];

  assign rd_go   = rd_any & ~ev_rd_closed;
  assign wr_go   = wr_any & ~ev_wr_closed & ~ev_clash;
  assign rd_addr = {row_of(rd_bank, row_flat), rd_col};
  assign wr_addr = {row_of(wr_bank, row_flat), wr_col};

  logic [NUM_BANKS-1:0] xp_rd_sel, xp_wr_sel;

  p2p_crosspoint #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_xp (
    .clk(clk), .rst_n(rst_n),
    .rd_go(rd_go), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_port(rd_is_b),
    .wr_go(wr_go), .wr_bank(wr_bank), .wr_addr(wr_addr), .wdata(gw_data),
    .rd_sel(xp_rd_sel), .wr_sel(xp_wr_sel),
    .bank_en(bank_en), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
    .gr_data(gr_data), .gr_valid(gr_valid), .gr_port(gr_port)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_dual_rd <= 1'b0;
      err_dual_wr <= 1'b0;
      err_clash   <= 1'b0;
      err_closed  <= 1'b0;
    end else begin
      err_dual_rd <= ev_dual_rd;
      err_dual_wr <= ev_dual_wr;
      err_clash   <= ev_clash;
      err_closed  <= ev_rd_closed | ev_wr_closed;
    end
  end
endmodule

// File: rtl/p2p_router_chk.sv
module p2p_router_chk
  import p2p_router_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CMD_W-1:0]     a_cmd,
  input logic [CMD_W-1:0]     b_cmd,
  input logic [NUM_BANKS-1:0] xp_rd_sel,
  input logic [NUM_BANKS-1:0] xp_wr_sel,
  input logic                 gr_valid,
  input logic                 err_dual_rd,
  input logic                 err_dual_wr,
  input logic                 err_clash
);
  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(xp_rd_sel)); // R3
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(xp_wr_sel)); // R3
  AST_XP_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n) (xp_rd_sel & xp_wr_sel) == '0); // R5
  AST_DUAL_RD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cmd == CMD_RD && b_cmd == CMD_RD) |=> err_dual_rd); // R3
  AST_DUAL_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cmd == CMD_WR && b_cmd == CMD_WR) |=> err_dual_wr && $countones(xp_wr_sel) <= 1); // R3
  AST_CLASH_DROP: assert property (@(posedge clk) disable iff (!rst_n) err_clash |-> xp_wr_sel == '0); // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (|xp_rd_sel) |=> gr_valid); // R9
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n) gr_valid |-> $past(|xp_rd_sel)); // R9
endmodule

bind p2p_bank_router p2p_router_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_cmd(a_cmd), .b_cmd(b_cmd),
  .xp_rd_sel(xp_rd_sel), .xp_wr_sel(xp_wr_sel), .gr_valid(gr_valid),
  .err_dual_rd(err_dual_rd), .err_dual_wr(err_dual_wr), .err_clash(err_clash)
);

// File: tb/test_p2p_bank_router.sv
module test_p2p_bank_router;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, RW = 8, CW = 6, DW = 16, AW = RW + CW;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, PRE = 3'd2, RD = 3'd3, WR = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] a_cmd, b_cmd;
  logic [1:0] a_bank, b_bank;
  logic [RW-1:0] a_row, b_row;
  logic [CW-1:0] a_col, b_col;
  logic [DW-1:0] gw_data, gr_data;
  logic gr_valid, gr_port;
  logic [NB-1:0] bank_en, bank_we;
  logic [NB*AW-1:0] bank_addr;
  logic [NB*DW-1:0] bank_wdata, bank_rdata;
  logic err_dual_rd, err_dual_wr, err_clash, err_closed;

  always #(CLK_PERIOD/2) clk = ~clk;

  p2p_bank_router i_p2p_bank_router (.*);

  function automatic logic [DW-1:0] pat(input int bk, input logic [AW-1:0] ad);
    return {bk[1:0], ad} ^ 16'hA5C3;
  endfunction

  always_comb begin
    for (int i = 0; i < NB; i++)
      bank_rdata[i*DW +: DW] = (bank_en[i] && !bank_we[i]) ? pat(i, bank_addr[i*AW +: AW]) : 16'hDEAD;
  end

  int n_cmp = 0, n_bad = 0;
  logic [RW-1:0] row_m [NB];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0] ac; logic [1:0] ab; logic [7:0] ar; logic [5:0] acl;
    logic [2:0] bc; logic [1:0] bb; logic [7:0] br; logic [5:0] bcl;
    logic [15:0] wd;
    logic [3:0] err;  // {dual_rd, dual_wr, clash, closed}
    logic [2:0] wx;   // {valid, bank}
    logic [3:0] rx;   // {valid, port, bank}
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{ACT,2'd0,8'h11,6'd0,  ACT,2'd1,8'h22,6'd0,  16'h0000, 4'b0000, 3'b000, 4'b0000},
    '{RD, 2'd0,8'h00,6'd3,  WR, 2'd1,8'h00,6'd5,  16'hBEEF, 4'b0000, 3'b101, 4'b1000},
    '{WR, 2'd0,8'h00,6'd1,  RD, 2'd1,8'h00,6'd2,  16'h1234, 4'b0000, 3'b100, 4'b1101},
    '{RD, 2'd0,8'h00,6'd4,  RD, 2'd1,8'h00,6'd6,  16'h0000, 4'b1000, 3'b000, 4'b1000},
    '{WR, 2'd0,8'h00,6'd7,  WR, 2'd1,8'h00,6'd8,  16'h5A5A, 4'b0100, 3'b100, 4'b0000},
    '{RD, 2'd1,8'h00,6'd9,  WR, 2'd1,8'h00,6'd10, 16'h7777, 4'b0010, 3'b000, 4'b1001},
    '{RD, 2'd2,8'h00,6'd1,  NOP,2'd0,8'h00,6'd0,  16'h0000, 4'b0001, 3'b000, 4'b0000},
    '{NOP,2'd0,8'h00,6'd0,  WR, 2'd3,8'h00,6'd2,  16'h1111, 4'b0001, 3'b000, 4'b0000},
    '{PRE,2'd0,8'h00,6'd0,  NOP,2'd0,8'h00,6'd0,  16'h0000, 4'b0000, 3'b000, 4'b0000},
    '{NOP,2'd0,8'h00,6'd0,  RD, 2'd0,8'h00,6'd1,  16'h0000, 4'b0001, 3'b000, 4'b0000},
    '{ACT,2'd2,8'h33,6'd0,  ACT,2'd2,8'h44,6'd0,  16'h0000, 4'b0000, 3'b000, 4'b0000},
    '{NOP,2'd0,8'h00,6'd0,  RD, 2'd2,8'h00,6'd7,  16'h0000, 4'b0000, 3'b000, 4'b1110},
    '{WR, 2'd2,8'h00,6'd9,  RD, 2'd1,8'h00,6'd4,  16'hC3C3, 4'b0000, 3'b110, 4'b1101},
    '{ACT,2'd3,8'h55,6'd0,  RD, 2'd3,8'h00,6'd0,  16'h0000, 4'b0001, 3'b000, 4'b0000},
    '{WR, 2'd1,8'h00,6'd11, RD, 2'd3,8'h00,6'd12, 16'h0F0F, 4'b0000, 3'b101, 4'b1111}
  };

  task automatic drive(input logic [2:0] ac, input logic [1:0] ab, input logic [7:0] ar, input logic [5:0] acl,
                       input logic [2:0] bc, input logic [1:0] bb, input logic [7:0] br, input logic [5:0] bcl,
                       input logic [15:0] wd);
    a_cmd = ac; a_bank = ab; a_row = ar; a_col = acl;
    b_cmd = bc; b_bank = bb; b_row = br; b_col = bcl; gw_data = wd;
  endtask

  task automatic idle();
    drive(NOP, 2'd0, 8'h00, 6'd0, NOP, 2'd0, 8'h00, 6'd0, 16'h0);
  endtask

  task automatic model_update(input vec_t v);
    if (v.bc == ACT) row_m[v.bb] = v.br;
    if (v.ac == ACT) row_m[v.ab] = v.ar;
  endtask

  task automatic run_vec(input int k, input vec_t v);
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] rexp;
    waddr = {row_m[v.wx[1:0]], (v.ac == WR) ? v.acl : v.bcl};
    raddr = {row_m[v.rx[1:0]], v.rx[2] ? v.bcl : v.acl};
    rexp  = pat(int'(v.rx[1:0]), raddr);
    @(negedge clk);
    drive(v.ac, v.ab, v.ar, v.acl, v.bc, v.bb, v.br, v.bcl, v.wd);
    @(negedge clk);
    idle();
    chk($sformatf("R3 R7 R8 err flags vec%0d", k), {err_dual_rd, err_dual_wr, err_clash, err_closed}, v.err);
    chk($sformatf("R4 write strobe vec%0d", k), bank_we, v.wx[2] ? (4'b1 << v.wx[1:0]) : 4'b0);
    chk($sformatf("R5 read select vec%0d", k), bank_en & ~bank_we, v.rx[3] ? (4'b1 << v.rx[1:0]) : 4'b0);
    if (v.wx[2]) begin
      chk($sformatf("R4 R10 write addr vec%0d", k), bank_addr[v.wx[1:0]*AW +: AW], waddr);
      chk($sformatf("R4 write data vec%0d", k), bank_wdata[v.wx[1:0]*DW +: DW], v.wd);
    end
    for (int i = 0; i < NB; i++)
      if (!(v.wx[2] && i == int'(v.wx[1:0])))
        chk($sformatf("R5 idle lane %0d vec%0d", i, k), bank_wdata[i*DW +: DW], 16'h0);
    model_update(v);
    @(negedge clk);
    chk($sformatf("R9 valid vec%0d", k), gr_valid, v.rx[3]);
    if (v.rx[3]) begin
      chk($sformatf("R9 R10 R2 read data vec%0d", k), gr_data, rexp);
      chk($sformatf("R9 read port vec%0d", k), gr_port, v.rx[2]);
    end
  endtask

  bit done = 0;
  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=%0d exp=<5000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) row_m[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset idle", {bank_en, bank_we, gr_valid, err_dual_rd, err_dual_wr, err_clash, err_closed}, '0);

    for (int k = 0; k < NV; k++) run_vec(k, VECS[k]);

    // R6: streaming reads on bank 1 (row 22) with writes to bank 2 (row 33)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 1 && i <= 6) begin
        chk($sformatf("R6 stream write strobe %0d", i), bank_we, 4'b0100);
        chk($sformatf("R6 stream write data %0d", i), bank_wdata[2*DW +: DW], 16'h9000 + 16'(i - 1));
      end
      if (i >= 2) begin
        chk($sformatf("R6 stream valid %0d", i), gr_valid, 1'b1);
        chk($sformatf("R6 stream data %0d", i), gr_data, pat(1, {8'h22, 6'(i - 2)}));
      end
      if (i < 6) drive(WR, 2'd2, 8'h00, 6'(i), RD, 2'd1, 8'h00, 6'(i), 16'h9000 + 16'(i));
      else idle();
    end

    // R1: a later reset closes every bank
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(NOP, 2'd0, 8'h00, 6'd0, RD, 2'd1, 8'h00, 6'd3, 16'h0);
    @(negedge clk);
    idle();
    chk("R1 R8 closed after reset", err_closed, 1'b1);
    chk("R1 no strobe after reset", bank_en, 4'b0);
    @(negedge clk);
    chk("R1 no read after reset", gr_valid, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule